// File: doc/BRIEF.md
# Processor Hotplug Register Block

This block is a 12-byte little-endian register window that software uses to manage hot-add and hot-remove of up to `NUM_CPU` processors. A selector register names one processor. All other registers act on the selected processor: its status byte, its control byte, the command byte and the two data dwords. The selector must name a processor below `NUM_CPU`. While it does not, the whole window reads as zero and all writes except a new selector value are dropped.

The command byte chooses how the data dwords behave. Command 0 runs a priority scan that moves the selector to the lowest-numbered processor with a pending insert or remove event. The data dword at offset 8 then reports the selector. Commands 1 and 2 turn a write to offset 8 into a load of the OST event register or the OST status register. A status load also raises a one-cycle report pulse that carries both values. Command 3 exposes the selected processor's 64-bit architecture ID. The ID is computed from parameters as follows: low word `ID_LO_BASE + idx*ID_STRIDE`, high word `ID_HI_TAG ^ idx`.

A plug input marks a processor as added, which sets its enabled and insert flags. On an enabled processor it can instead post a remove event. A completed eject clears the processor's enabled flag and produces a one-cycle eject output with the processor's index.

Top module: `cpuhp_regfile`

## Requirements
- R1: Reset clears every per-processor flag except that processor 0 comes back enabled (status 0x01), returns the command byte to 0 and clears both pulse outputs. The selector keeps its value across reset.
- R2: While the selector is `NUM_CPU` or greater, every read returns 0. Writes to offsets 4, 5 and 8 have no effect, and the command byte, flags and OST registers hold their values.
- R3: The status byte read at offset 4 has the following layout: bit 0 enabled, bit 1 insert event, bit 2 remove event, bit 4 eject handed to firmware. Bits 3 and 5–7 read 0.
- R4: A control write to offset 4 behaves as follows. Bit 1 set clears the selected processor's insert event. Bit 2 set clears its remove event.
- R5: A control write with bit 3 set to an enabled processor performs the eject. It clears that processor's enabled, insert and firmware-eject flags. On the next cycle `eject_pulse` is high for exactly one cycle, and `eject_idx` holds the index.
- R6: A control write with bit 4 set sets the firmware-eject flag. If bit 3 is also set in the same write, the eject takes priority and the flag ends up clear.
- R7: Writing 0 to the command byte at offset 5 has the following effects. The selector moves to the lowest index whose insert or remove flag is set, and offset 8 then reads the selector. If no processor has a pending event, the selector is unchanged. The selector changes only on a bus write.
- R8: With command 3, offset 8 reads the low word and offset 0 reads the high word of the selected processor's ID. With command 0, offset 0 reads 0.
- R9: With command 1, a write to offset 8 loads `ost_event`. With command 2, a write to offset 8 loads `ost_status`, and `ost_valid` pulses for one cycle after the write.
- R10: Offsets other than 0, 4 and 8 read 0, as do writes to them. Command values other than 0 and 3 make offsets 0 and 8 read 0.
- R11: A plug event with `plug_remove` = 0 sets the enabled and insert flags. With `plug_remove` = 1 on an enabled processor, it sets the remove flag. A plug event takes precedence over a clearing control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one access |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 32 | Write data, little-endian (byte accesses use bits 7:0) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| plug_valid | input | 1 | Plug event strobe |
| plug_remove | input | 1 | 0 = hot-add, 1 = remove request |
| plug_idx | input | IDX_W | Processor index of the plug event |
| eject_pulse | output | 1 | One-cycle pulse when an eject completes |
| eject_idx | output | IDX_W | Index of the ejected processor |
| ost_valid | output | 1 | One-cycle pulse after an OST status load |
| ost_event | output | 32 | OST event register |
| ost_status | output | 32 | OST status register |

## Verification
The hazard is a hardware plug event and a software control write that act on the same processor in the same cycle. One sets the insert flag and the other clears it. The bench provokes this by driving `plug_valid` for a disabled processor on the same edge as a control write of 0x02 to that processor. It then reads the status byte, which must be 0x03: the new event survives the clear. A second overlap puts an event scan together with flags that earlier clears left partly set. The bench judges it by the selector that offset 8 returns afterwards.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_SEL  = 4'd0;
    localparam logic [OFS_W-1:0] OFS_STAT = 4'd4;
    localparam logic [OFS_W-1:0] OFS_CMD  = 4'd5;
    localparam logic [OFS_W-1:0] OFS_DATA = 4'd8;

    localparam logic [7:0] CMD_SCAN    = 8'd0;
    localparam logic [7:0] CMD_OST_EV  = 8'd1;
    localparam logic [7:0] CMD_OST_ST  = 8'd2;
    localparam logic [7:0] CMD_ARCH_ID = 8'd3;

    // Per-processor state flags
    typedef struct packed {
        logic fw_eject;
        logic remove_ev;
        logic insert_ev;
        logic enabled;
    } slot_t;

    // Decoded control byte
    typedef struct packed {
        logic clr_ins;
        logic clr_rem;
        logic do_eject;
        logic hand_fw;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [7:0] b);
        ctl_t c;
        c.clr_ins  = b[1];
        c.clr_rem  = b[2];
        c.do_eject = b[3];
        c.hand_fw  = b[4];
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input slot_t s);
        return {3'b000, s.fw_eject, 1'b0, s.remove_ev, s.insert_ev, s.enabled};
    endfunction

    function automatic logic [63:0] arch_id(input logic [31:0] idx,
                                            input logic [31:0] lo_base,
                                            input logic [31:0] stride,
                                            input logic [31:0] hi_tag);
        logic [31:0] lo;
        lo = lo_base + idx * stride;
        return {hi_tag ^ idx, lo};
    endfunction

endpackage

// File: rtl/cpuhp_slot.sv
module cpuhp_slot
    import cpuhp_pkg::*;
#(
    parameter bit IS_BOOT = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ctl_we,
    input  ctl_t  ctl,
    input  logic  plug_add,
    input  logic  plug_rem,
    output slot_t st,
    output logic  eject_fire
);

    slot_t st_q;
    slot_t st_d;

    assign eject_fire = ctl_we && ctl.do_eject && st_q.enabled;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (ctl.clr_ins) st_d.insert_ev = 1'b0;
            if (ctl.clr_rem) st_d.remove_ev = 1'b0;
            if (ctl.hand_fw) st_d.fw_eject  = 1'b1;
            if (ctl.do_eject && st_q.enabled) begin
                st_d.enabled   = 1'b0;
                st_d.insert_ev = 1'b0;
                st_d.fw_eject  = 1'b0;
            end
        end
        // hardware events win over software clears
        if (plug_add) begin
            st_d.enabled   = 1'b1;
            st_d.insert_ev = 1'b1;
        end
        if (plug_rem && st_q.enabled) begin
            st_d.remove_ev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{fw_eject: 1'b0, remove_ev: 1'b0, insert_ev: 1'b0, enabled: IS_BOOT};
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/cpuhp_scan.sv
module cpuhp_scan #(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_CPU-1:0] pend,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CPU - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cpuhp_rdmux.sv
module cpuhp_rdmux
    import cpuhp_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             sel_valid,
    input  logic [7:0]       cmd,
    input  logic [31:0]      sel,
    input  logic [7:0]       stat,
    input  logic [63:0]      id,
    output logic [31:0]      rdata
);

    always_comb begin
        rdata = '0;
        if (sel_valid) begin
            unique case (addr)
                OFS_SEL: begin
                    if (cmd == CMD_ARCH_ID) rdata = id[63:32];
                end
                OFS_STAT: begin
                    rdata = {24'd0, stat};
                end
                OFS_DATA: begin
                    if (cmd == CMD_SCAN)         rdata = sel;
                    else if (cmd == CMD_ARCH_ID) rdata = id[31:0];
                end
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cpuhp_regfile.sv
module cpuhp_regfile
    import cpuhp_pkg::*;
#(
    parameter int          NUM_CPU    = 8,
    parameter logic [31:0] ID_LO_BASE = 32'h0000_0010,
    parameter logic [31:0] ID_STRIDE  = 32'h0000_0002,
    parameter logic [31:0] ID_HI_TAG  = 32'hA500_0000,
    localparam int         IDX_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             plug_valid,
    input  logic             plug_remove,
    input  logic [IDX_W-1:0] plug_idx,
    output logic             eject_pulse,
    output logic [IDX_W-1:0] eject_idx,
    output logic             ost_valid,
    output logic [31:0]      ost_event,
    output logic [31:0]      ost_status
);

    localparam logic [31:0] CPU_LIMIT = 32'(NUM_CPU);

    // Selector: initialised once, untouched by reset
    logic [31:0] sel_q = '0;
    logic [7:0]  cmd_q;
    logic        sel_valid;
    logic [IDX_W-1:0] sel_idx;

    assign sel_valid = (sel_q < CPU_LIMIT);
    assign sel_idx   = sel_q[IDX_W-1:0];

    logic wr_sel, wr_ctl, wr_cmd, wr_data, scan_go;
    assign wr_sel  = bus_wr && (bus_addr == OFS_SEL);
    assign wr_ctl  = bus_wr && (bus_addr == OFS_STAT) && sel_valid;
    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD)  && sel_valid;
    assign wr_data = bus_wr && (bus_addr == OFS_DATA) && sel_valid;
    assign scan_go = wr_cmd && (bus_wdata[7:0] == CMD_SCAN);

    ctl_t ctl;
    assign ctl = decode_ctl(bus_wdata[7:0]);

    slot_t              slot_st [NUM_CPU];
    logic [NUM_CPU-1:0] pend;
    logic [NUM_CPU-1:0] fire;

    generate
        for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
            logic hit;
            logic add_g;
            logic rem_g;
            assign hit   = (sel_idx == IDX_W'(g));
            assign add_g = plug_valid && !plug_remove && (plug_idx == IDX_W'(g));
            assign rem_g = plug_valid &&  plug_remove && (plug_idx == IDX_W'(g));

            cpuhp_slot #(.IS_BOOT(g == 0)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .ctl_we     (wr_ctl && hit),
                .ctl        (ctl),
                .plug_add   (add_g),
                .plug_rem   (rem_g),
                .st         (slot_st[g]),
                .eject_fire (fire[g])
            );

            assign pend[g] = slot_st[g].insert_ev || slot_st[g].remove_ev;
        end
    endgenerate

    logic             scan_found;
    logic [IDX_W-1:0] scan_idx;

    cpuhp_scan #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_scan (
        .pend  (pend),
        .found (scan_found),
        .idx   (scan_idx)
    );

    always_ff @(posedge clk) begin
        if (wr_sel) begin
            sel_q <= bus_wdata;
        end else if (scan_go && scan_found) begin
            sel_q <= 32'(scan_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= CMD_SCAN;
            ost_event   <= '0;
            ost_status  <= '0;
            ost_valid   <= 1'b0;
            eject_pulse <= 1'b0;
            eject_idx   <= '0;
        end else begin
            ost_valid   <= 1'b0;
            eject_pulse <= |fire;
            if (|fire) eject_idx <= sel_idx;
            if (wr_cmd) cmd_q <= bus_wdata[7:0];
            if (wr_data) begin
                if (cmd_q == CMD_OST_EV) begin
                    ost_event <= bus_wdata;
                end else if (cmd_q == CMD_OST_ST) begin
                    ost_status <= bus_wdata;
                    ost_valid  <= 1'b1;
                end
            end
        end
    end

    slot_t       cur_slot;
    logic [63:0] cur_id;

    always_comb begin
        cur_slot = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (sel_idx == IDX_W'(i)) cur_slot = slot_st[i];
        end
    end

    assign cur_id = arch_id(32'(sel_idx), ID_LO_BASE, ID_STRIDE, ID_HI_TAG);

    cpuhp_rdmux u_rdmux (
        .addr      (bus_addr),
        .sel_valid (sel_valid),
        .cmd       (cmd_q),
        .sel       (sel_q),
        .stat      (status_byte(cur_slot)),
        .id        (cur_id),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/cpuhp_regfile_chk.sv
module cpuhp_regfile_chk #(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             eject_pulse,
    input logic [IDX_W-1:0] eject_idx,
    input logic             ost_valid,
    input logic [31:0]      sel_q
);

    AST_INVALID_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel_q >= 32'(NUM_CPU)) |-> (bus_rdata == 32'd0)); // R2

    AST_RSVD_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != 4'd0 && bus_addr != 4'd4 && bus_addr != 4'd8) |-> (bus_rdata == 32'd0)); // R10

    AST_SEL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(sel_q)); // R7

    AST_EJECT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |=> !eject_pulse); // R5

    AST_EJECT_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |-> (32'(eject_idx) < 32'(NUM_CPU))); // R5

    AST_OST_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        ost_valid |-> ($past(bus_wr) && $past(bus_addr) == 4'd8)); // R9

endmodule

bind cpuhp_regfile cpuhp_regfile_chk #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .eject_pulse (eject_pulse),
    .eject_idx   (eject_idx),
    .ost_valid   (ost_valid),
    .sel_q       (sel_q)
);

// File: tb/cpuhp_regfile_bench.sv
module cpuhp_regfile_bench;

    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             bus_wr;
    logic [3:0]       bus_addr;
    logic [31:0]      bus_wdata;
    logic [31:0]      bus_rdata;
    logic             plug_valid;
    logic             plug_remove;
    logic [IDX_W-1:0] plug_idx;
    logic             eject_pulse;
    logic [IDX_W-1:0] eject_idx;
    logic             ost_valid;
    logic [31:0]      ost_event;
    logic [31:0]      ost_status;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    cpuhp_regfile u_cpuhp_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .plug_valid(plug_valid), .plug_remove(plug_remove), .plug_idx(plug_idx),
        .eject_pulse(eject_pulse), .eject_idx(eject_idx),
        .ost_valid(ost_valid), .ost_event(ost_event), .ost_status(ost_status)
    );

    // expected ID per processor: low = 0x10 + 2*i, high = 0xA5000000 ^ i
    function automatic logic [31:0] id_lo(input int i);
        return 32'h10 + 32'(i) * 32'd2;
    endfunction
    function automatic logic [31:0] id_hi(input int i);
        return 32'hA500_0000 ^ 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic plug(input logic rem, input int idx);
        @(negedge clk);
        plug_valid = 1'b1; plug_remove = rem; plug_idx = IDX_W'(idx);
        @(posedge clk);
        @(negedge clk);
        plug_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [3:0]  a;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd0, 32'd0,          8'd8},
        '{1'b0, 4'd5, 32'd3,          8'd8},
        '{1'b1, 4'd8, 32'h0000_0010,  8'd8},  // R8 low word cpu0
        '{1'b1, 4'd0, 32'hA500_0000,  8'd8},  // R8 high word cpu0
        '{1'b0, 4'd0, 32'd5,          8'd8},
        '{1'b1, 4'd8, 32'h0000_001A,  8'd8},
        '{1'b1, 4'd0, 32'hA500_0005,  8'd8},
        '{1'b0, 4'd5, 32'd0,          8'd7},  // R7 scan from cpu5 finds cpu3
        '{1'b1, 4'd8, 32'd3,          8'd7},
        '{1'b1, 4'd4, 32'h03,         8'd3},  // R3 enabled+insert
        '{1'b1, 4'd0, 32'd0,          8'd8},  // command 0: offset 0 reads 0
        '{1'b0, 4'd4, 32'h02,         8'd4},
        '{1'b1, 4'd4, 32'h01,         8'd4},  // R4 insert cleared
        '{1'b0, 4'd5, 32'd0,          8'd7},
        '{1'b1, 4'd8, 32'd5,          8'd7},
        '{1'b0, 4'd4, 32'h02,         8'd4},
        '{1'b0, 4'd5, 32'd0,          8'd7},  // nothing pending
        '{1'b1, 4'd8, 32'd5,          8'd7},
        '{1'b0, 4'd0, 32'd2,          8'd7},
        '{1'b0, 4'd5, 32'd0,          8'd7},
        '{1'b1, 4'd8, 32'd2,          8'd7},
        '{1'b0, 4'd5, 32'd7,          8'd10},
        '{1'b1, 4'd8, 32'd0,          8'd10}, // R10 reserved command
        '{1'b1, 4'd0, 32'd0,          8'd10},
        '{1'b1, 4'd1, 32'd0,          8'd10},
        '{1'b1, 4'd6, 32'd0,          8'd10},
        '{1'b0, 4'd0, 32'd3,          8'd2},
        '{1'b0, 4'd5, 32'd3,          8'd2},
        '{1'b1, 4'd8, 32'h0000_0016,  8'd2},
        '{1'b0, 4'd0, 32'd8,          8'd2},  // R2 invalid selector
        '{1'b1, 4'd8, 32'd0,          8'd2},
        '{1'b1, 4'd0, 32'd0,          8'd2},
        '{1'b1, 4'd4, 32'd0,          8'd2},
        '{1'b0, 4'd5, 32'd0,          8'd2},
        '{1'b0, 4'd4, 32'h08,         8'd2},
        '{1'b0, 4'd0, 32'd3,          8'd2},
        '{1'b1, 4'd8, 32'h0000_0016,  8'd2},  // command held at 3
        '{1'b1, 4'd4, 32'h01,         8'd2},  // eject was dropped
        '{1'b1, 4'd4, 32'h01,         8'd3}
    };

    initial begin
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        plug_valid = 1'b0; plug_remove = 1'b0; plug_idx = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd4, 32'h01, "R1");
        rd(4'd8, 32'd0,  "R1");
        check("R1", {31'd0, ost_valid},   32'd0);
        check("R1", {31'd0, eject_pulse}, 32'd0);

        // R11 hot-add cpus 3 and 5
        plug(1'b0, 3);
        plug(1'b0, 5);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rd)
                rd(VEC[i].a, VEC[i].d, $sformatf("R%0d", VEC[i].req));
            else
                wr(VEC[i].a, VEC[i].d);
        end

        // R6 firmware handover, R5 eject
        wr(4'd0, 32'd3);
        wr(4'd4, 32'h10);
        rd(4'd4, 32'h11, "R6");
        wr(4'd4, 32'h08);
        check("R5", {31'd0, eject_pulse}, 32'd1);
        check("R5", 32'(eject_idx), 32'd3);
        rd(4'd4, 32'h00, "R5");
        @(negedge clk);
        check("R5", {31'd0, eject_pulse}, 32'd0);

        // R6 bit 3 and bit 4 together on cpu0
        wr(4'd0, 32'd0);
        wr(4'd4, 32'h18);
        rd(4'd4, 32'h00, "R6");
        plug(1'b0, 0);
        wr(4'd4, 32'h02);

        // R9 OST registers
        wr(4'd5, 32'd1);
        wr(4'd8, 32'h0000_0103);
        check("R9", {31'd0, ost_valid}, 32'd0);
        check("R9", ost_event, 32'h0000_0103);
        wr(4'd5, 32'd2);
        wr(4'd8, 32'h0000_0055);
        check("R9", {31'd0, ost_valid}, 32'd1);
        check("R9", ost_status, 32'h0000_0055);
        check("R9", ost_event, 32'h0000_0103);
        @(negedge clk);
        check("R9", {31'd0, ost_valid}, 32'd0);

        // R11 remove request on enabled cpu5, then scan finds it
        plug(1'b1, 5);
        wr(4'd0, 32'd0);
        wr(4'd5, 32'd0);
        rd(4'd8, 32'd5, "R11");
        rd(4'd4, 32'h05, "R11");

        // R11 plug-add and insert-clear land on cpu6 in the same cycle
        wr(4'd0, 32'd6);
        @(negedge clk);
        plug_valid = 1'b1; plug_remove = 1'b0; plug_idx = 3'd6;
        bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h02;
        @(posedge clk);
        @(negedge clk);
        plug_valid = 1'b0; bus_wr = 1'b0;
        rd(4'd4, 32'h03, "R11");

        // R1 selector retained across reset, flags cleared
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(4'd8, 32'd6, "R1");
        rd(4'd4, 32'h00, "R1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule